// File: doc/BRIEF.md
# Inclusive Last-Level Cache Slice Directory with Core Snoop Filter

This block is the tag and directory half of one slice of a shared, inclusive last-level cache. The slice is 16-way set associative over 64-byte lines. Every resident line carries a presence vector with one bit per core, and each bit means that core may hold a copy. Because the slice includes everything the cores hold, a line that is absent here cannot be in any core. The presence bits therefore act as a snoop filter. An external snoop only reaches the cores whose bit is set on a resident line, and it disturbs no core otherwise.

Requests enter on a valid/ready stream. Each one carries an operation code, a requesting core and a byte address. Each request produces exactly one response on a second valid/ready stream, one cycle after acceptance. Core reads and ownership requests that miss allocate a line. A miss is reported as hit=0, and the requester forwards it to memory. When allocation displaces a valid line, the response carries the victim's line address and the set of cores that must be back-invalidated, and the victim's presence bits are dropped along with it.

A static configuration input switches off ways in groups of four to trim capacity. It may only change while no request or response is outstanding, and lines in a group must be flushed before that group is switched off.

Top module: `sf_slice_dir`

## Requirements
- R1: After reset rsp_valid is 0, req_ready is 1 and no line is resident, so every first lookup misses.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1, and req_ready equals (not rsp_valid) or rsp_ready. Its response appears in the next cycle and stays unchanged while rsp_valid is 1 and rsp_ready is 0.
- R3: Address bits [5:0] are ignored, bits [9:6] select the set and bits [31:10] are the tag. rsp_hit is 1 exactly when an enabled way of that set holds a valid line with that tag, and rsp_way then gives that way.
- R4: A snoop (op code 2) that hits returns the line's presence vector in rsp_snp_mask, where bit i stands for core i. A snoop that misses returns 0. A snoop changes no state.
- R5: A core read (op code 0) that hits sets the requester's presence bit and returns rsp_snp_mask = 0.
- R6: An ownership request (op code 1) that hits returns the presence bits of all other cores in rsp_snp_mask, after which only the requester's bit remains set.
- R7: A read or ownership miss with at least one enabled way allocates a line (rsp_alloc = 1) whose presence vector holds only the requester's bit, and it returns rsp_snp_mask = 0.
- R8: When an allocation finds an enabled invalid way, it picks the lowest-numbered one, and rsp_evict and rsp_binv_mask are 0.
- R9: When every enabled way of the set is valid, the victim comes from a pseudo-LRU tree over the enabled ways and is never the way touched most recently in that set. Read and ownership hits and allocations count as touches.
- R10: Evicting a valid line sets rsp_evict, reports the victim's line address (offset bits zero) on rsp_binv_addr and its presence vector on rsp_binv_mask. rsp_binv_mask is 0 whenever rsp_evict is 0.
- R11: Bit g of cfg_way_off disables ways 4g to 4g+3. A disabled way never hits and is never a victim. With all ways disabled, a miss returns rsp_alloc = 0.
- R12: A probe (op code 3) reports hit or miss only, with rsp_snp_mask = 0, no allocation and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_way_off | input | 4 | One disable bit per group of four ways |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Slice can take a request this cycle |
| req_op | input | 2 | 0 read, 1 ownership, 2 snoop, 3 probe |
| req_core | input | 2 | Requesting core index |
| req_addr | input | 32 | Byte address of the request |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_hit | output | 1 | Line found in an enabled way |
| rsp_alloc | output | 1 | A line was allocated for this miss |
| rsp_evict | output | 1 | The allocation displaced a valid line |
| rsp_way | output | 4 | Way hit or allocated |
| rsp_snp_mask | output | 4 | Cores to snoop or invalidate for this request |
| rsp_binv_mask | output | 4 | Cores to back-invalidate for the victim |
| rsp_binv_addr | output | 32 | Line address of the victim |

## Verification
The bench fills a set until it is full and then keeps allocating. A wrong replacement tree shows up as a victim equal to the way just touched, or as a victim in a disabled group. A free-way finder that ignores validity or enable evicts live lines while free slots remain, so the reported back-invalidate mask and address disagree with the tracked contents. Ownership hits after several cores have read the same line catch a design that snoops the requester itself or keeps stale bits, and snoops to absent lines catch any non-zero mask on a miss. Random back-pressure on the response stream exposes responses that change while stalled, and requests that are lost or duplicated at the edge.

// File: rtl/sf_pkg.sv
package sf_pkg;
  // Request operation codes; values are visible at the req_op pins.
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_OWN   = 2'd1,
    OP_SNOOP = 2'd2,
    OP_PROBE = 2'd3
  } sf_op_e;
endpackage

// File: rtl/sf_way_enable.sv
// Expands the per-group disable bits into a per-way enable vector.
module sf_way_enable #(
  parameter int NUM_WAYS   = 16,
  parameter int GROUP_WAYS = 4
) (
  input  logic [NUM_WAYS/GROUP_WAYS-1:0] grp_off,
  output logic [NUM_WAYS-1:0]            way_en
);
  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    assign way_en[w] = ~grp_off[w / GROUP_WAYS];
  end
endmodule

// File: rtl/sf_tag_match.sv
// Parallel tag compare over one set row, with presence vector of the hit way.
module sf_tag_match #(
  parameter int NUM_WAYS  = 16,
  parameter int TAG_W     = 22,
  parameter int NUM_CORES = 4,
  parameter int WAY_W     = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0][TAG_W-1:0]     row_tag,
  input  logic [NUM_WAYS-1:0]                row_vld,
  input  logic [NUM_WAYS-1:0][NUM_CORES-1:0] row_cvb,
  input  logic [NUM_WAYS-1:0]                way_en,
  input  logic [TAG_W-1:0]                   look_tag,
  output logic [NUM_WAYS-1:0]                match_vec,
  output logic                               hit,
  output logic [WAY_W-1:0]                   hit_way,
  output logic [NUM_CORES-1:0]               hit_cvb
);
  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    assign match_vec[w] = row_vld[w] & way_en[w] & (row_tag[w] == look_tag);
  end

  assign hit = |match_vec;

  always_comb begin
    hit_way = '0;
    hit_cvb = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (match_vec[w]) begin
        hit_way = WAY_W'(w);
        hit_cvb = row_cvb[w];
      end
    end
  end
endmodule

// File: rtl/sf_plru.sv
// Victim choice and tree update for one set. Tree node k (heap index,
// root = 1) is stored in bit k-1; a 1 steers the victim to the right half.
module sf_plru #(
  parameter int NUM_WAYS = 16,
  parameter int WAY_W    = $clog2(NUM_WAYS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_WAYS-1:0]   way_en,
  input  logic [NUM_WAYS-1:0]   row_vld,
  input  logic [NUM_WAYS-2:0]   tree_q,
  input  logic [WAY_W-1:0]      touch_way,
  output logic [WAY_W-1:0]      victim_way,
  output logic                  victim_any,
  output logic [NUM_WAYS-2:0]   tree_nxt
);
  localparam int LVLS = WAY_W;

  logic [2*NUM_WAYS-1:1] sub_en;
  logic [WAY_W-1:0]      inv_way;
  logic                  inv_found;
  logic [WAY_W-1:0]      tree_way;

  // Enabled-way presence per subtree.
  always_comb begin
    for (int i = 0; i < NUM_WAYS; i++) sub_en[NUM_WAYS+i] = way_en[i];
    for (int i = NUM_WAYS - 1; i >= 1; i--) sub_en[i] = sub_en[2*i] | sub_en[2*i+1];
  end

  assign victim_any = sub_en[1];

  // Lowest enabled invalid way.
  always_comb begin
    inv_way   = '0;
    inv_found = 1'b0;
    for (int i = NUM_WAYS - 1; i >= 0; i--) begin
      if (way_en[i] && !row_vld[i]) begin
        inv_way   = WAY_W'(i);
        inv_found = 1'b1;
      end
    end
  end

  // Tree walk that never descends into a subtree with no enabled way.
  always_comb begin
    int node;
    node = 1;
    for (int l = 0; l < LVLS; l++) begin
      if (!sub_en[2*node+1])    node = 2 * node;
      else if (!sub_en[2*node]) node = 2 * node + 1;
      else                      node = 2 * node + int'(tree_q[node-1]);
    end
    tree_way = WAY_W'(node - NUM_WAYS);
  end

  assign victim_way = inv_found ? inv_way : tree_way;

  // Point every node on the touched way's path away from it.
  always_comb begin
    int n;
    tree_nxt = tree_q;
    n = NUM_WAYS + int'(touch_way);
    for (int l = 0; l < LVLS; l++) begin
      tree_nxt[(n>>1)-1] = ~n[0];
      n = n >> 1;
    end
  end

  // R11
  victim_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    victim_any |-> way_en[victim_way]);
endmodule

// File: rtl/sf_slice_dir.sv
module sf_slice_dir #(
  parameter int NUM_WAYS   = 16,
  parameter int NUM_SETS   = 16,
  parameter int NUM_CORES  = 4,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int GROUP_WAYS = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NUM_WAYS/GROUP_WAYS-1:0]      cfg_way_off,
  input  logic                                req_valid,
  output logic                                req_ready,
  input  logic [1:0]                          req_op,
  input  logic [$clog2(NUM_CORES)-1:0]        req_core,
  input  logic [ADDR_W-1:0]                   req_addr,
  output logic                                rsp_valid,
  input  logic                                rsp_ready,
  output logic                                rsp_hit,
  output logic                                rsp_alloc,
  output logic                                rsp_evict,
  output logic [$clog2(NUM_WAYS)-1:0]         rsp_way,
  output logic [NUM_CORES-1:0]                rsp_snp_mask,
  output logic [NUM_CORES-1:0]                rsp_binv_mask,
  output logic [ADDR_W-1:0]                   rsp_binv_addr
);
  import sf_pkg::*;

  localparam int OFS_W  = $clog2(LINE_BYTES);
  localparam int SET_W  = $clog2(NUM_SETS);
  localparam int TAG_W  = ADDR_W - OFS_W - SET_W;
  localparam int WAY_W  = $clog2(NUM_WAYS);
  localparam int GRP_SH = $clog2(GROUP_WAYS);

  // Directory state, one row per set.
  logic [NUM_WAYS-1:0][TAG_W-1:0]     tag_q  [NUM_SETS];
  logic [NUM_WAYS-1:0]                vld_q  [NUM_SETS];
  logic [NUM_WAYS-1:0][NUM_CORES-1:0] cvb_q  [NUM_SETS];
  logic [NUM_WAYS-2:0]                plru_q [NUM_SETS];

  // Request decode.
  sf_op_e           op;
  logic [SET_W-1:0] set_idx;
  logic [TAG_W-1:0] look_tag;
  logic             accept;

  assign op       = sf_op_e'(req_op);
  assign set_idx  = req_addr[OFS_W +: SET_W];
  assign look_tag = req_addr[ADDR_W-1 -: TAG_W];
  assign req_ready = ~rsp_valid | rsp_ready;
  assign accept    = req_valid & req_ready;

  logic [NUM_WAYS-1:0] way_en;

  sf_way_enable #(.NUM_WAYS(NUM_WAYS), .GROUP_WAYS(GROUP_WAYS)) u_en (
    .grp_off (cfg_way_off),
    .way_en  (way_en)
  );

  logic [NUM_WAYS-1:0]  match_vec;
  logic                 hit;
  logic [WAY_W-1:0]     hit_way;
  logic [NUM_CORES-1:0] hit_cvb;

  sf_tag_match #(.NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W), .NUM_CORES(NUM_CORES)) u_match (
    .row_tag   (tag_q[set_idx]),
    .row_vld   (vld_q[set_idx]),
    .row_cvb   (cvb_q[set_idx]),
    .way_en    (way_en),
    .look_tag  (look_tag),
    .match_vec (match_vec),
    .hit       (hit),
    .hit_way   (hit_way),
    .hit_cvb   (hit_cvb)
  );

  logic                is_core, do_alloc, touch;
  logic [WAY_W-1:0]    touch_way, victim_way;
  logic                victim_any;
  logic [NUM_WAYS-2:0] tree_nxt;

  sf_plru #(.NUM_WAYS(NUM_WAYS)) u_plru (
    .clk        (clk),
    .rst_n      (rst_n),
    .way_en     (way_en),
    .row_vld    (vld_q[set_idx]),
    .tree_q     (plru_q[set_idx]),
    .touch_way  (touch_way),
    .victim_way (victim_way),
    .victim_any (victim_any),
    .tree_nxt   (tree_nxt)
  );

  // Per-request decision.
  logic [NUM_CORES-1:0] req_bit, hit_cvb_nxt, snp_mask, binv_mask;
  logic                 evict;
  logic [ADDR_W-1:0]    binv_addr;
  logic [TAG_W-1:0]     vic_tag;

  assign is_core   = (op == OP_READ) || (op == OP_OWN);
  assign do_alloc  = is_core & ~hit & victim_any;
  assign touch     = is_core & (hit | do_alloc);
  assign touch_way = hit ? hit_way : victim_way;
  assign req_bit   = NUM_CORES'(1) << req_core;

  always_comb begin
    hit_cvb_nxt = (op == OP_OWN) ? req_bit : (hit_cvb | req_bit);
    snp_mask    = '0;
    if (hit) begin
      case (op)
        OP_SNOOP: snp_mask = hit_cvb;
        OP_OWN:   snp_mask = hit_cvb & ~req_bit;
        default:  snp_mask = '0;
      endcase
    end
  end

  assign vic_tag   = tag_q[set_idx][victim_way];
  assign evict     = do_alloc & vld_q[set_idx][victim_way];
  assign binv_mask = evict ? cvb_q[set_idx][victim_way] : '0;
  assign binv_addr = {vic_tag, set_idx, {OFS_W{1'b0}}};

  // State update on acceptance.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        vld_q[s]  <= '0;
        cvb_q[s]  <= '0;
        plru_q[s] <= '0;
      end
    end else if (accept) begin
      if (touch) plru_q[set_idx] <= tree_nxt;
      if (hit && is_core) cvb_q[set_idx][hit_way] <= hit_cvb_nxt;
      if (do_alloc) begin
        vld_q[set_idx][victim_way] <= 1'b1;
        cvb_q[set_idx][victim_way] <= req_bit;
      end
    end
  end

  // Tags carry no reset: a tag is only compared when its valid bit is set.
  always_ff @(posedge clk) begin
    if (accept && do_alloc) tag_q[set_idx][victim_way] <= look_tag;
  end

  // Response register.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_hit       <= 1'b0;
      rsp_alloc     <= 1'b0;
      rsp_evict     <= 1'b0;
      rsp_way       <= '0;
      rsp_snp_mask  <= '0;
      rsp_binv_mask <= '0;
      rsp_binv_addr <= '0;
    end else if (accept) begin
      rsp_valid     <= 1'b1;
      rsp_hit       <= hit;
      rsp_alloc     <= do_alloc;
      rsp_evict     <= evict;
      rsp_way       <= touch_way;
      rsp_snp_mask  <= snp_mask;
      rsp_binv_mask <= binv_mask;
      rsp_binv_addr <= evict ? binv_addr : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R2
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid &&
      $stable({rsp_hit, rsp_alloc, rsp_evict, rsp_way, rsp_snp_mask, rsp_binv_mask, rsp_binv_addr}));

  // R3
  one_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $onehot0(match_vec));

  // R4
  snp_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> rsp_snp_mask == '0);

  // R10
  binv_evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_binv_mask != '0 |-> rsp_evict && rsp_alloc);

  // R11
  alloc_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_alloc |-> !cfg_way_off[rsp_way >> GRP_SH]);
endmodule

// File: tb/tb_sf_slice_dir.sv
module tb_sf_slice_dir;
  import sf_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NW = 16;
  localparam int NS = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_way_off = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = '0;
  logic [1:0]  req_core = '0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_hit, rsp_alloc, rsp_evict;
  logic [3:0]  rsp_way, rsp_snp_mask, rsp_binv_mask;
  logic [31:0] rsp_binv_addr;

  sf_slice_dir dut (
    .clk(clk), .rst_n(rst_n), .cfg_way_off(cfg_way_off),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_core(req_core), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_alloc(rsp_alloc), .rsp_evict(rsp_evict), .rsp_way(rsp_way),
    .rsp_snp_mask(rsp_snp_mask), .rsp_binv_mask(rsp_binv_mask),
    .rsp_binv_addr(rsp_binv_addr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  bit bp_en    = 0;

  task automatic chk(input string rq, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // Behavioural model of the slice contents.
  typedef struct { sf_op_e op; int core; logic [31:0] addr; } req_t;
  req_t        pq[$];
  logic [25:0] m_line [NS][NW];
  bit          m_vld  [NS][NW];
  logic [3:0]  m_cvb  [NS][NW];
  int          m_mru  [NS];

  function automatic bit way_on(int w);
    return !cfg_way_off[w/4];
  endfunction

  function automatic logic [31:0] mk(int tag, int set, int ofs);
    return (32'(tag) << 10) | (32'(set) << 6) | 32'(ofs);
  endfunction

  task automatic process_rsp(input req_t r);
    int s, hw, fw, vw;
    logic [25:0] ln;
    logic [3:0]  rb, exp_mask;
    s  = int'(r.addr[9:6]);
    ln = r.addr[31:6];
    rb = 4'b1 << r.core;
    hw = -1;
    for (int w = NW - 1; w >= 0; w--)
      if (way_on(w) && m_vld[s][w] && m_line[s][w] == ln) hw = w;
    chk("R3", "hit", rsp_hit, hw >= 0);
    if (hw >= 0) chk("R3", "hit way", rsp_way, hw);
    exp_mask = '0;
    case (r.op)
      OP_SNOOP: begin
        if (hw >= 0) exp_mask = m_cvb[s][hw];
        chk("R4", "snoop mask", rsp_snp_mask, exp_mask);
        chk("R4", "snoop alloc", rsp_alloc, 0);
      end
      OP_PROBE: begin
        chk("R12", "probe mask", rsp_snp_mask, 0);
        chk("R12", "probe alloc", rsp_alloc, 0);
      end
      default: begin
        if (hw >= 0) begin
          chk("R7", "alloc on hit", rsp_alloc, 0);
          if (r.op == OP_OWN) begin
            chk("R6", "own mask", rsp_snp_mask, m_cvb[s][hw] & ~rb);
            m_cvb[s][hw] = rb;
          end else begin
            chk("R5", "read mask", rsp_snp_mask, 0);
            m_cvb[s][hw] = m_cvb[s][hw] | rb;
          end
          m_mru[s] = hw;
        end else if (cfg_way_off == 4'hF) begin
          chk("R11", "alloc all off", rsp_alloc, 0);
          chk("R11", "mask all off", rsp_snp_mask, 0);
        end else begin
          chk("R7", "alloc", rsp_alloc, 1);
          chk("R7", "fill mask", rsp_snp_mask, 0);
          fw = -1;
          for (int w = NW - 1; w >= 0; w--)
            if (way_on(w) && !m_vld[s][w]) fw = w;
          if (fw >= 0) begin
            chk("R8", "free way", rsp_way, fw);
            chk("R8", "no evict", rsp_evict, 0);
            chk("R10", "binv mask none", rsp_binv_mask, 0);
            vw = fw;
          end else begin
            vw = int'(rsp_way);
            chk("R11", "victim enabled", way_on(vw), 1);
            chk("R9", "victim not mru", vw != m_mru[s], 1);
            chk("R10", "evict", rsp_evict, 1);
            chk("R10", "binv mask", rsp_binv_mask, m_cvb[s][vw]);
            chk("R10", "binv addr", rsp_binv_addr, {m_line[s][vw], 6'b0});
          end
          m_line[s][vw] = ln;
          m_vld[s][vw]  = 1;
          m_cvb[s][vw]  = rb;
          m_mru[s]      = vw;
        end
      end
    endcase
  endtask

  // Monitor: compares on every clock, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2", "rsp_valid vs outstanding", rsp_valid, pq.size() != 0);
      chk("R2", "req_ready", req_ready, !rsp_valid || rsp_ready);
      if (rsp_valid && rsp_ready && pq.size() != 0) process_rsp(pq.pop_front());
      if (req_valid && req_ready) begin
        req_t r;
        r.op = sf_op_e'(req_op); r.core = int'(req_core); r.addr = req_addr;
        pq.push_back(r);
      end
    end
  end

  // Response back-pressure.
  logic [15:0] bp_lf = 16'hACE1;
  always @(posedge clk) begin
    #1;
    bp_lf = {bp_lf[14:0], bp_lf[15] ^ bp_lf[13] ^ bp_lf[12] ^ bp_lf[10]};
    rsp_ready = bp_en ? (bp_lf[0] | bp_lf[3]) : 1'b1;
  end

  task automatic send(input sf_op_e op, input int core, input logic [31:0] addr);
    req_valid = 1'b1;
    req_op    = op;
    req_core  = 2'(core);
    req_addr  = addr;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (pq.size() != 0 || rsp_valid) begin
      @(posedge clk); #1;
    end
  endtask

  initial begin
    for (int s = 0; s < NS; s++) m_mru[s] = -1;
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  logic [15:0] st_lf = 16'h1D2B;

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R1", "rsp_valid in reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "rsp_valid after reset", rsp_valid, 0);
    chk("R1", "req_ready after reset", req_ready, 1);
    @(posedge clk); #1;

    // Fill set 3 from core 0 (R1 first misses, R8 in-order ways), odd offsets (R3).
    for (int t = 1; t <= 16; t++) send(OP_READ, 0, mk(t, 3, t));
    // Sharing, snoops, ownership.
    send(OP_READ, 1, mk(2, 3, 0));
    send(OP_READ, 2, mk(2, 3, 63));
    send(OP_SNOOP, 0, mk(2, 3, 5));
    send(OP_OWN, 3, mk(2, 3, 0));
    send(OP_SNOOP, 0, mk(2, 3, 0));
    send(OP_PROBE, 1, mk(5, 3, 0));
    send(OP_SNOOP, 0, mk(99, 3, 0));
    send(OP_PROBE, 0, mk(99, 3, 0));
    send(OP_SNOOP, 0, mk(99, 3, 0));
    drain();

    // Evictions with back-pressure (R9, R10).
    bp_en = 1;
    for (int t = 17; t <= 30; t++) send(OP_READ, t % 4, mk(t, 3, 0));
    for (int t = 1; t <= 16; t++) send(OP_OWN, t % 4, mk(t, 3, 0));
    drain();

    // Group 1 off: fresh set fills skip ways 4..7; set 3 probed only (R11).
    cfg_way_off = 4'b0010;
    @(posedge clk); #1;
    for (int t = 1; t <= 20; t++) send(OP_READ, 1, mk(t, 5, 0));
    for (int t = 17; t <= 30; t++) send(OP_PROBE, 0, mk(t, 3, 0));
    drain();
    cfg_way_off = 4'hF;
    @(posedge clk); #1;
    for (int t = 40; t <= 44; t++) send(OP_READ, 2, mk(t, 6, 0));
    send(OP_SNOOP, 0, mk(1, 5, 0));
    drain();

    // Random mix, sets 7 and 8 with all ways, sets 9 and 10 with two groups.
    cfg_way_off = 4'b0000;
    @(posedge clk); #1;
    for (int i = 0; i < 700; i++) begin
      st_lf = {st_lf[14:0], st_lf[15] ^ st_lf[13] ^ st_lf[12] ^ st_lf[10]};
      send(sf_op_e'(st_lf[1:0]), int'(st_lf[3:2]), mk(int'(st_lf[8:4]) % 24, 7 + int'(st_lf[9]), 0));
    end
    drain();
    cfg_way_off = 4'b0101;
    @(posedge clk); #1;
    for (int i = 0; i < 700; i++) begin
      st_lf = {st_lf[14:0], st_lf[15] ^ st_lf[13] ^ st_lf[12] ^ st_lf[10]};
      send(sf_op_e'(st_lf[1:0]), int'(st_lf[3:2]), mk(int'(st_lf[8:4]) % 14, 9 + int'(st_lf[9]), 0));
    end
    drain();
    repeat (3) @(posedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule